// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns a floating-point value, given in an unpacked working format, into a signed 32-bit integer. It always discards the fraction toward zero, whatever rounding mode the surrounding unit has selected. The input is a class code, a sign, a signed unbiased exponent and a significand whose leading one sits in the top bit.

The result is a two's-complement integer plus two flags. A loss flag reports that nonzero fraction bits were thrown away. An invalid flag reports an input that cannot be represented: a value too large in magnitude, an infinity or a NaN. The invalid cases saturate. The limit is asymmetric, so the most negative integer still converts exactly.

The block takes one request per cycle with an input strobe. The registered result, its strobe and both flags appear on the next clock edge.

Top module: `trunc_f2i`

## Requirements
- R1: While reset is asserted and right after it, `out_valid`, `result`, `loss` and `invalid` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `loss` and `invalid` are high only while `out_valid` is high. `result` keeps its last value when `in_valid` is low.
- R3: Class code 2'b00 (zero) gives result 0 with both flags low, whatever the sign, exponent and significand.
- R4: For class code 2'b01 (number) with exponent e in 0..31, the magnitude is `sig >> (63 - e)`, truncated toward zero. The result is that magnitude, two's-complement negated when the sign is 1.
- R5: `loss` is high for a number whose discarded low bits are not all zero. A negative exponent gives result 0 with `loss` high.
- R6: A number with exponent 32 or more, up to +2047, is invalid.
- R7: A number whose truncated magnitude is at least 0x80000000 plus the sign bit is invalid. So -2^31 converts exactly, and +2^31 does not.
- R8: Class codes 2'b10 (infinity) and 2'b11 (NaN) are invalid for either sign.
- R9: Every invalid case raises `invalid`, forces `loss` low and gives 0x7FFFFFFF when positive or 0x80000000 when negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| in_cls | input | 2 | Class: 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | 12 | Signed unbiased exponent |
| in_sig | input | 64 | Significand, leading one at bit 63 |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Signed integer result |
| loss | output | 1 | Nonzero fraction bits were discarded |
| invalid | output | 1 | Input not representable; result saturated |

## Verification
The bench builds the block with its default parameters: a 12-bit exponent, a 64-bit significand and a 32-bit result. These widths put both ends of the exponent range (-2048 and +2047) within reach, along with every shift from 32 to 63 positions and the 2^31 saturation edge for each sign. The vectors cover the values on either side of that edge: 0x7FFFFFFF, +2^31, -2^31 with and without discarded bits, and 0xFFFFFFFF negative. They also cover zero, infinity and NaN for both signs, and the case where a negative exponent discards every bit.

// File: rtl/trunc_f2i.sv
module trunc_f2i #(
  parameter int EXP_W = 12,
  parameter int SIG_W = 64,
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_cls,
  input  logic             in_sign,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0] in_sig,
  output logic             out_valid,
  output logic [INT_W-1:0] result,
  output logic             loss,
  output logic             invalid
);
  localparam int SH_W = $clog2(SIG_W);
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);
  localparam logic [INT_W:0] HALF = (INT_W+1)'(1) << (INT_W-1);
  localparam logic [INT_W-1:0] MAXPOS = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [1:0] CLS_ZERO = 2'b00;
  localparam logic [1:0] CLS_NUM  = 2'b01;

  logic             exp_neg, exp_big;
  logic [SH_W-1:0]  sh;
  logic [INT_W-1:0] mag, sat;
  logic             dropped, mag_ovf, bad;
  logic [INT_W-1:0] nxt_res;
  logic             nxt_loss;

  assign exp_neg = in_exp[EXP_W-1];
  assign exp_big = $signed(in_exp) >= EXP_LIM;
  assign sh      = SH_W'(SIG_W-1) - in_exp[SH_W-1:0];
  assign mag     = exp_neg ? '0 : INT_W'(in_sig >> sh);
  assign dropped = exp_neg ? |in_sig : |(in_sig & ~({SIG_W{1'b1}} << sh));
  assign mag_ovf = {1'b0, mag} >= HALF + (INT_W+1)'(in_sign);
  assign sat     = MAXPOS + INT_W'(in_sign);

  always_comb begin
    bad      = 1'b0;
    nxt_res  = '0;
    nxt_loss = 1'b0;
    if (in_cls == CLS_NUM) begin
      if (exp_big || mag_ovf) bad = 1'b1;
      else begin
        nxt_res  = in_sign ? (~mag + 1'b1) : mag;
        nxt_loss = dropped;
      end
    end else if (in_cls != CLS_ZERO) begin
      bad = 1'b1;
    end
    if (bad) nxt_res = sat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      loss      <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      loss      <= in_valid & nxt_loss;
      invalid   <= in_valid & bad;
      if (in_valid) result <= nxt_res;
    end
  end
endmodule

// File: rtl/trunc_f2i_chk.sv
module trunc_f2i_chk #(
  parameter int EXP_W = 12,
  parameter int SIG_W = 64,
  parameter int INT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_cls,
  input logic             in_sign,
  input logic [EXP_W-1:0] in_exp,
  input logic [SIG_W-1:0] in_sig,
  input logic             out_valid,
  input logic [INT_W-1:0] result,
  input logic             loss,
  input logic             invalid
);
  localparam logic [INT_W-1:0] MAXPOS = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MINNEG = {1'b1, {(INT_W-1){1'b0}}};

  assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !loss && !invalid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_cls == 2'b00 |=> result == '0 && !loss && !invalid);
  assert_special_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_cls[1] |=> invalid);
  assert_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> !loss && (result == MAXPOS || result == MINNEG));
endmodule

bind trunc_f2i trunc_f2i_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W), .INT_W(INT_W)) u_chk (.*);

// File: tb/tb_trunc_f2i.sv
module tb_trunc_f2i;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_cls = 2'b00;
  logic        in_sign = 1'b0;
  logic [11:0] in_exp = '0;
  logic [63:0] in_sig = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        loss;
  logic        invalid;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  trunc_f2i dut (.*);

  // row: cls, sign, exp, sig, expected result, loss, invalid
  localparam int NV = 20;
  localparam logic [112:0] VEC [NV] = '{
    {2'b00, 1'b1, 12'h005, 64'h8000_0000_0000_0001, 32'h0000_0000, 1'b0, 1'b0}, // R3
    {2'b01, 1'b0, 12'h000, 64'h8000_0000_0000_0000, 32'h0000_0001, 1'b0, 1'b0}, // R4
    {2'b01, 1'b0, 12'h000, 64'hC000_0000_0000_0000, 32'h0000_0001, 1'b1, 1'b0}, // R5
    {2'b01, 1'b1, 12'h000, 64'hC000_0000_0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R4 R5
    {2'b01, 1'b0, 12'h00A, 64'h8020_0000_0000_0000, 32'h0000_0401, 1'b0, 1'b0}, // R4
    {2'b01, 1'b1, 12'h00A, 64'h8020_0000_0000_0000, 32'hFFFF_FBFF, 1'b0, 1'b0}, // R4
    {2'b01, 1'b0, 12'h004, 64'hA800_0000_0000_0001, 32'h0000_0015, 1'b1, 1'b0}, // R5
    {2'b01, 1'b0, 12'h01E, 64'hFFFF_FFFE_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0}, // R7
    {2'b01, 1'b0, 12'h01F, 64'h8000_0000_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R7
    {2'b01, 1'b1, 12'h01F, 64'h8000_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b0}, // R7
    {2'b01, 1'b1, 12'h01F, 64'h8000_0000_8000_0000, 32'h8000_0000, 1'b1, 1'b0}, // R7 R5
    {2'b01, 1'b1, 12'h01F, 64'hFFFF_FFFF_0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R7 R9
    {2'b01, 1'b0, 12'h020, 64'h8000_0000_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R6
    {2'b01, 1'b1, 12'h7FF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0000, 1'b0, 1'b1}, // R6 R9
    {2'b01, 1'b0, 12'hFFF, 64'h8000_0000_0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R5
    {2'b01, 1'b1, 12'h800, 64'h8000_0000_0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R5
    {2'b10, 1'b0, 12'h000, 64'h0000_0000_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R8
    {2'b10, 1'b1, 12'h000, 64'h0000_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R8
    {2'b11, 1'b1, 12'h3FF, 64'hC000_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R8 R9
    {2'b11, 1'b0, 12'h000, 64'hC000_0000_0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1}  // R8
  };
  localparam int REQ [NV] = '{3, 4, 5, 4, 4, 4, 5, 7, 7, 7, 7, 9, 6, 6, 5, 5, 8, 8, 8, 8};

  task automatic check(input string req, input logic [31:0] r, input logic l,
                       input logic i, input logic [31:0] er, input logic el,
                       input logic ei);
    tests++;
    if (r !== er || l !== el || i !== ei) begin
      fails++;
      $display("FAIL %s: got result=%h loss=%b invalid=%b, expected result=%h loss=%b invalid=%b",
               req, r, l, i, er, el, ei);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic s, input logic [11:0] e,
                       input logic [63:0] g);
    @(negedge clk);
    in_valid = 1'b1; in_cls = c; in_sign = s; in_exp = e; in_sig = g;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", result, loss, invalid, 32'h0, 1'b0, 1'b0);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: got out_valid=%b, expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", result, loss, invalid, 32'h0, 1'b0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][112:111], VEC[k][110], VEC[k][109:98], VEC[k][97:34]);
      tests++;
      if (out_valid !== 1'b1) begin
        fails++;
        $display("FAIL R2: got out_valid=%b, expected 1 (row %0d)", out_valid, k);
      end
      check($sformatf("R%0d row %0d", REQ[k], k), result, loss, invalid,
            VEC[k][33:2], VEC[k][1], VEC[k][0]);
    end

    // R2: after an invalid result, the next idle cycle drops strobe and flags, result holds
    drive(2'b11, 1'b1, 12'h0, 64'h0);
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2: got out_valid=%b, expected 0", out_valid);
    end
    check("R2 hold", result, loss, invalid, 32'h8000_0000, 1'b0, 1'b0);

    // R2: inputs changing without strobe leave the result alone
    in_cls = 2'b01; in_sign = 1'b0; in_exp = 12'h003; in_sig = 64'hF000_0000_0000_0000;
    repeat (2) @(negedge clk);
    check("R2 idle", result, loss, invalid, 32'h8000_0000, 1'b0, 1'b0);

    // R2 R5: back-to-back requests each appear one cycle later
    @(negedge clk);
    in_valid = 1'b1; in_cls = 2'b01; in_sign = 1'b0; in_exp = 12'h003; in_sig = 64'hF000_0000_0000_0000;
    @(negedge clk);
    check("R4 b2b first", result, loss, invalid, 32'h0000_000F, 1'b0, 1'b0);
    in_cls = 2'b01; in_sign = 1'b1; in_exp = 12'hFFE; in_sig = 64'h8000_0000_0000_0000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 b2b second", result, loss, invalid, 32'h0, 1'b1, 1'b0);

    // R1: reset mid-stream clears outputs
    in_valid = 1'b1; in_cls = 2'b10;
    rst_n = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 re-reset", result, loss, invalid, 32'h0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule